// File: doc/BRIEF.md
# RC5 Biphase Infrared Frame Transmitter

This block turns one command word into a complete 14-symbol RC5 infrared frame and drives a carrier-enable line that gates an external 36 kHz carrier source. Every symbol is split into two equal half-bit periods, one with carrier on and one with carrier off. A zero bit is sent as carrier then silence, and a one bit is sent as silence then carrier. The time base is a one-cycle `tick` strobe, nominally at 10 kHz. Each half-bit lasts `HALF_TICKS` ticks. The default of 9 ticks gives about 889 µs per half-bit.

A request is a 5-bit address and a 7-bit command, handed over on a valid/ready channel. A transfer happens only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole frame. Back-pressure therefore lasts one full frame, and a source that wants its request sent must hold `req_valid` and its data until `req_ready` returns. If `req_valid` is raised while `req_ready` is low and then dropped, nothing is latched and no state changes.

The frame is sent most-significant symbol first, in this order:
- a start symbol with value 1;
- the inverted command bit 6;
- an internal toggle bit;
- address bits 4 down to 0;
- command bits 5 down to 0.

The toggle bit inverts on every accepted request and keeps its value between frames.

Top module: `rc5_ir_tx`

## Requirements
- R1: After reset, `carrier_en` and `busy` are 0, `req_ready` is 1, and the stored toggle bit is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `busy` is 1 and `req_ready` is 0 until the frame ends.
- R3: A symbol of value 0 shows `carrier_en`=1 for its first half-bit and 0 for its second half-bit. A symbol of value 1 shows the reverse. Each half-bit lasts exactly `HALF_TICKS` tick pulses.
- R4: The first symbol of every frame has value 1.
- R5: The 14 symbols, in the order sent, are:
  - symbol 13: 1;
  - symbol 12: NOT cmd[6];
  - symbol 11: the toggle bit;
  - symbols 10 down to 6: addr[4:0];
  - symbols 5 down to 0: cmd[5:0].
- R6: The toggle bit inverts on each accepted request, and the frame carries the inverted value. The first frame after reset therefore carries toggle = 1, and later frames alternate.
- R7: `req_valid` raised while `busy` is 1 has no effect. The current frame goes on unchanged, and the toggle bit sent in the next accepted frame is still the inverse of the one in the previous frame.
- R8: On the tick that ends the 28th half-bit, `busy` falls and `carrier_en` is 0. No further carrier appears until a new request is accepted.
- R9: Clock cycles without a tick pulse do not advance the frame; `carrier_en` holds its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base strobe (nominally 10 kHz) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Transmitter idle; a request is taken when valid and ready are both 1 |
| req_addr | input | 5 | Device address, sent MSB first |
| req_cmd | input | 7 | Command; bit 6 is sent inverted, bits 5..0 are sent MSB first |
| carrier_en | output | 1 | Gate for the external 36 kHz carrier |
| busy | output | 1 | A frame is in progress |

## Verification
The embedded assertions check the following on every cycle:
- the half-bit counter stays within its range;
- no counter or symbol state moves without a tick;
- `busy` rises after every accepted request;
- the toggle bit flips only on an accepted request;
- `busy` can fall only at the end of the last half-bit.

The actual symbol values, their order, the Manchester polarity and the exact half-bit lengths seen on `carrier_en` can only be shown by the bench. It runs a tick-counting model of the frame and also decodes captured waveforms for several addresses, commands and toggle states. The same applies to rejected requests made mid-frame and to tick-free stalls.

// File: rtl/rc5_pkg.sv
package rc5_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned CMD_W  = 7;
  localparam int unsigned SYMS   = 14;
  localparam int unsigned IDX_W  = $clog2(SYMS);
  typedef logic [SYMS-1:0] frame_t;
endpackage

// File: rtl/rc5_frame_builder.sv
module rc5_frame_builder
  import rc5_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              tog,
  output frame_t            frame
);
  // Symbol SYMS-1 leaves first: start, extension (inverted cmd MSB), toggle, address, command
  always_comb begin
    frame = {1'b1, ~cmd[CMD_W-1], tog, addr, cmd[CMD_W-2:0]};
  end
endmodule

// File: rtl/rc5_halfbit_timer.sv
module rc5_halfbit_timer #(
  parameter int unsigned HALF_TICKS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic half_done
);
  localparam int unsigned CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

  logic [CW-1:0] cnt;

  assign half_done = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt <= '0;
    end else if (run && tick) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R9
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !clear) |=> $stable(cnt));
endmodule

// File: rtl/rc5_tx_seq.sv
module rc5_tx_seq
  import rc5_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  frame_t frame_in,
  input  logic   half_done,
  output logic   busy,
  output logic   carrier
);
  localparam logic [IDX_W-1:0] FIRST = IDX_W'(SYMS - 1);

  frame_t           shreg;
  logic [IDX_W-1:0] idx;
  logic             second_half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      shreg       <= '0;
      idx         <= '0;
      second_half <= 1'b0;
    end else if (accept) begin
      busy        <= 1'b1;
      shreg       <= frame_in;
      idx         <= FIRST;
      second_half <= 1'b0;
    end else if (busy && half_done) begin
      if (!second_half) begin
        second_half <= 1'b1;
      end else begin
        second_half <= 1'b0;
        if (idx == '0) begin
          busy <= 1'b0;
        end else begin
          idx   <= idx - 1'b1;
          shreg <= {shreg[SYMS-2:0], 1'b0};
        end
      end
    end
  end

  // Value 1: silence then carrier; value 0: carrier then silence
  always_comb begin
    carrier = busy && (shreg[SYMS-1] ? second_half : !second_half);
  end

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && idx == FIRST && !second_half));

  // R8
  end_of_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(idx) == '0 && $past(second_half)));

  // R9
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !half_done && !accept) |=> ($stable(idx) && $stable(second_half)));
endmodule

// File: rtl/rc5_ir_tx.sv
module rc5_ir_tx
  import rc5_pkg::*;
#(
  parameter int unsigned HALF_TICKS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  output logic              carrier_en,
  output logic              busy
);
  logic   toggle_q;
  logic   accept;
  logic   half_done;
  frame_t frame;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)      toggle_q <= 1'b0;
    else if (accept) toggle_q <= !toggle_q;
  end

  rc5_frame_builder u_build (
    .addr  (req_addr),
    .cmd   (req_cmd),
    .tog   (!toggle_q),
    .frame (frame)
  );

  rc5_halfbit_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .run       (busy),
    .tick      (tick),
    .half_done (half_done)
  );

  rc5_tx_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .frame_in  (frame),
    .half_done (half_done),
    .busy      (busy),
    .carrier   (carrier_en)
  );

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (toggle_q != $past(toggle_q)));

  // R7
  toggle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(toggle_q));
endmodule

// File: tb/sim_rc5_ir_tx.sv
module sim_rc5_ir_tx;
  localparam int HALF = 9;
  localparam int HALVES = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic req_valid = 1'b0;
  logic [4:0] req_addr = '0;
  logic [6:0] req_cmd = '0;
  logic req_ready, carrier_en, busy;
  logic tick_en = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rc5_ir_tx #(.HALF_TICKS(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cmd(req_cmd),
    .carrier_en(carrier_en), .busy(busy)
  );

  // Tick generator: one pulse every 4 clocks when enabled
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 4;
      tick = tick_en && (div == 0);
    end
  end

  // Behavioural reference: tick count since acceptance
  bit m_act = 0;
  bit m_tog = 0;
  int m_t = 0;
  bit [13:0] m_vec = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_tog = 0; m_t = 0;
    end else if (m_act) begin
      if (tick) begin
        m_t++;
        if (m_t == HALVES * HALF) m_act = 0;
      end
    end else if (req_valid) begin
      m_tog = !m_tog;
      m_vec = {1'b1, ~req_cmd[6], m_tog, req_addr, req_cmd[5:0]};
      m_act = 1;
      m_t = 0;
    end
  end

  function automatic bit exp_carrier();
    int k;
    bit b;
    if (!m_act) return 1'b0;
    k = m_t / HALF;
    b = m_vec[13 - k / 2];
    return b ? (k % 2 == 1) : (k % 2 == 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison and waveform capture
  bit halfbuf [HALVES];
  bit compare_on = 0;
  always @(negedge clk) begin
    cycles++;
    if (compare_on) begin
      chk(carrier_en == exp_carrier(), "R3 R5 carrier per-cycle", carrier_en, exp_carrier());
      chk(busy == m_act, "R2 R8 busy per-cycle", busy, m_act);
      chk(req_ready == !m_act, "R2 ready per-cycle", req_ready, !m_act);
      if (m_act) halfbuf[m_t / HALF] = carrier_en;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic send(input logic [4:0] a, input logic [6:0] c);
    @(negedge clk);
    req_addr = a; req_cmd = c; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1 && req_ready == 1'b0, "R2 busy after accept", busy, 1);
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
  endtask

  task automatic decode(input bit [13:0] expv, input string tag);
    bit [13:0] got;
    bit shape_ok = 1;
    for (int s = 0; s < 14; s++) begin
      got[13 - s] = halfbuf[2 * s + 1];
      if (halfbuf[2 * s] == halfbuf[2 * s + 1]) shape_ok = 0;
    end
    chk(shape_ok, "R3 biphase halves differ", shape_ok, 1);
    chk(got[13] == 1'b1, "R4 start symbol", got[13], 1);
    chk(got == expv, tag, got, expv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(carrier_en == 0 && busy == 0 && req_ready == 1, "R1 reset outputs",
        {carrier_en, busy, req_ready}, 3'b001);
    rst_n = 1'b1;
    compare_on = 1;
    tick_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(carrier_en == 0, "R1 idle after reset", carrier_en, 0);

    // Frame A: first toggle is 1 (R6), ext bit cmd[6]=1 -> 0
    send(5'h15, 7'h4A);
    // R7 request mid-frame is ignored
    repeat (100) @(negedge clk);
    req_addr = 5'h0A; req_cmd = 7'h11; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R9 stall: no ticks, carrier holds
    begin
      bit c0;
      tick_en = 1'b0;
      repeat (2) @(negedge clk);
      c0 = carrier_en;
      repeat (30) @(negedge clk);
      chk(carrier_en == c0 && busy == 1, "R9 hold without tick", carrier_en, c0);
      tick_en = 1'b1;
    end
    wait_done();
    decode({1'b1, 1'b0, 1'b1, 5'h15, 6'h0A}, "R5 R6 frame A symbols");
    // R8 end of frame, and no repeat
    chk(carrier_en == 0 && busy == 0, "R8 end state", {carrier_en, busy}, 0);
    begin
      bit seen = 0;
      repeat (200) begin
        @(negedge clk);
        if (carrier_en || busy) seen = 1;
      end
      chk(!seen, "R8 single frame per request", seen, 0);
    end

    // Frame B: toggle 0 (R6, R7 ignored request did not flip it), cmd[6]=0 -> 1
    send(5'h00, 7'h3F);
    wait_done();
    decode({1'b1, 1'b1, 1'b0, 5'h00, 6'h3F}, "R5 R6 R7 frame B symbols");

    // Frame C: toggle back to 1, all-ones fields; request arrives with a tick
    send(5'h1F, 7'h7F);
    wait_done();
    decode({1'b1, 1'b0, 1'b1, 5'h1F, 6'h3F}, "R5 R6 frame C symbols");

    // Frame D: alternating bits
    send(5'h0A, 7'h15);
    wait_done();
    decode({1'b1, 1'b1, 1'b0, 5'h0A, 6'h15}, "R5 R6 frame D symbols");

    repeat (10) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule